// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block sits between a set of interrupt request lines and a downstream local interrupt controller. A host sees two 32-bit locations. One is a select register, which names an internal register by index. The other is a data window, through which that register is read or written. Each input line owns a table entry. The entry holds a vector, a delivery mode, a destination, a destination mode, a trigger mode and a mask. When a line raises an interrupt, the block sends one message on a valid/ready output that carries those fields.

Edge-triggered lines are latched as pending on a rising transition and are consumed once they have been serviced. Level-triggered lines stay pending while the line is high. Once such a message has been accepted, the entry holds a remote-acknowledge flag, and the entry is not delivered again until an end-of-interrupt with its vector is broadcast back. Several entries may need service in the same cycle. They are evaluated one at a time, and the lowest entry index goes first. Only the fixed and lowest-priority delivery modes are forwarded. Entries in any other mode are consumed silently.

Top module: `irq_redir_router`

## Requirements
- R1: After reset every configuration word reads 0x00010000 (only the mask at bit 16 set), every destination word reads 0, the ID register reads 0 and `msg_valid` is low.
- R2: A 32-bit write at offset 0x00 loads the select register. A 32-bit read at 0x00 returns its low 8 bits. A 32-bit access at offset 0x10 reads or writes the register that the select value names.
- R3: A byte read at offset 0x10+k (k = 0..3) returns bits 8k+7:8k of the selected register. Byte writes change neither the select register nor any internal register.
- R4: Register 0 keeps only bits 27:24 of a write. Register 2 reads the same value as register 0. Register 1 reads (NUM_LINES-1)<<16 | 0x11. Writes to registers 1 and 2 are ignored. Any other index outside the table reads 0, and writes to it have no effect.
- R5: Entry n has its configuration word at index 0x10+2n and its destination word at 0x11+2n. The writable configuration bits are vector 7:0, delivery mode 10:8, destination mode 11, bit 13, trigger 15 (1 = level) and mask 16. Bits 12, 14 and 31:17 keep their values on a write. Of a destination write only bits 31:24 are stored.
- R6: A rising input on an unmasked edge entry yields exactly one message. A rising input on a masked edge entry is discarded and is not delivered after a later unmask.
- R7: A rising input on a level entry makes it pending even when masked, and unmasking it later delivers it. A falling input on a level entry withdraws the pending request.
- R8: Acceptance of a level message sets remote-acknowledge (config bit 14), which is still clear while the message waits. While the bit is set, re-evaluation, including the re-evaluation caused by a configuration write, delivers nothing.
- R9: An end-of-interrupt clears bit 14 on every entry whose vector matches and whose bit 14 is set, and then re-evaluates it. If the line is still high, a new message follows. A non-matching vector changes nothing.
- R10: Only delivery modes 0 and 1 produce a message. An entry in any other mode is consumed without output: an edge entry loses its pending state, and a level entry sets bit 14.
- R11: A message carries the entry's vector, delivery mode, trigger mode (1 = level), destination (the stored bits 31:24) and destination mode.
- R12: A message stays valid with stable fields until it is accepted. At least one idle cycle follows each acceptance. When entries need evaluation together, the lowest index is delivered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Host access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte access, 0 = 32-bit access |
| bus_addr | input | 5 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access |
| irq_in | input | NUM_LINES | Interrupt request lines |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_level | output | 1 | Message trigger mode, 1 = level |
| msg_dest | output | 8 | Message destination |
| msg_destmode | output | 1 | Message destination mode |

## Verification
An end-of-interrupt for a level entry and the falling edge of that entry's line can land in the same cycle. The end-of-interrupt then schedules a re-evaluation just as the pending request is withdrawn. The bench drives both in one cycle on a delivered level entry. It expects no further message, and it expects bit 14 to read back clear. A fresh rising edge must then deliver normally. Two edge entries raised in the same cycle also collide in the scheduler, and the bench judges that case by the order of the vectors that emerge.

// File: rtl/irq_redir_router.sv
module irq_redir_router #(
  parameter int         NUM_LINES = 24,
  parameter logic [7:0] VERSION   = 8'h11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic                 bus_byte,
  input  logic [4:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 eoi_valid,
  input  logic [7:0]           eoi_vector,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [7:0]           msg_vector,
  output logic [2:0]           msg_dmode,
  output logic                 msg_level,
  output logic [7:0]           msg_dest,
  output logic                 msg_destmode
);
  localparam int          IW        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [7:0]  TBL_BASE  = 8'h10;
  localparam logic [7:0]  TBL_END   = 8'(16 + 2 * NUM_LINES);
  localparam logic [16:0] CFG_WMASK = 17'h1AFFF;
  localparam logic [16:0] CFG_RESET = 17'h10000;

  logic [16:0]          cfg_q [NUM_LINES];
  logic [7:0]           dst_q [NUM_LINES];
  logic [NUM_LINES-1:0] irr_q, line_q, need_q, irr_d, need_d;
  logic [NUM_LINES-1:0] ev_rise, eoi_hit;
  logic [7:0]           sel_q;
  logic [3:0]           id_q;
  logic [IW-1:0]        held_q;

  // host access decode
  logic        wr_word, sel_wr, win_wr, in_tbl, cfg_wr, dst_wr;
  logic [7:0]  toff;
  logic [IW-1:0] widx;
  logic [31:0] reg_val;
  logic        unused_wdata;

  assign wr_word = bus_en & bus_we & ~bus_byte;
  assign sel_wr  = wr_word && bus_addr == 5'h00;
  assign win_wr  = wr_word && bus_addr == 5'h10;
  assign in_tbl  = sel_q >= TBL_BASE && sel_q < TBL_END;
  assign toff    = sel_q - TBL_BASE;
  assign widx    = IW'(toff[7:1]);
  assign cfg_wr  = win_wr & in_tbl & ~toff[0];
  assign dst_wr  = win_wr & in_tbl & toff[0];
  assign unused_wdata = ^bus_wdata[23:17];

  always_comb begin
    reg_val = 32'h0;
    if (sel_q == 8'd0 || sel_q == 8'd2)
      reg_val = {4'h0, id_q, 24'h0};
    else if (sel_q == 8'd1)
      reg_val = {8'h0, 8'(NUM_LINES - 1), 8'h0, VERSION};
    else if (in_tbl)
      reg_val = toff[0] ? {dst_q[widx], 24'h0} : {15'h0, cfg_q[widx]};
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_en && !bus_we) begin
      if (!bus_byte) begin
        if (bus_addr == 5'h00)      bus_rdata = {24'h0, sel_q};
        else if (bus_addr == 5'h10) bus_rdata = reg_val;
      end else if (bus_addr[4:2] == 3'b100) begin
        bus_rdata = {24'h0, reg_val[8 * int'(bus_addr[1:0]) +: 8]};
      end
    end
  end

  // input events
  logic [NUM_LINES-1:0] rise, fall;
  assign rise = irq_in & ~line_q;
  assign fall = ~irq_in & line_q;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      ev_rise[i] = rise[i] & ~(~cfg_q[i][15] & cfg_q[i][16]);
      eoi_hit[i] = eoi_valid && cfg_q[i][7:0] == eoi_vector && cfg_q[i][14];
    end
  end

  // scheduler: lowest pending evaluation first, stalled while a message waits
  logic          found;
  logic [IW-1:0] pick;
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (need_q[i]) begin
        found = 1'b1;
        pick  = IW'(i);
      end
  end

  logic [16:0] pcfg;
  logic go, p_live, p_lvl, p_fwd, p_blocked, p_send, p_drop, accept;
  assign pcfg      = cfg_q[pick];
  assign go        = found & ~msg_valid;
  assign p_live    = irr_q[pick] & ~pcfg[16];
  assign p_lvl     = pcfg[15];
  assign p_fwd     = pcfg[10:9] == 2'b00;
  assign p_blocked = p_lvl & pcfg[14];
  assign p_send    = go & p_live & ~p_blocked & p_fwd;
  assign p_drop    = go & p_live & ~p_blocked & ~p_fwd;
  assign accept    = msg_valid & msg_ready;

  always_comb begin
    irr_d  = irr_q;
    need_d = need_q;
    if (go) begin
      need_d[pick] = 1'b0;
      if (p_live && !p_lvl) irr_d[pick] = 1'b0;
    end
    for (int i = 0; i < NUM_LINES; i++) begin
      if (fall[i] && cfg_q[i][15]) irr_d[i] = 1'b0;
      if (ev_rise[i]) begin
        irr_d[i]  = 1'b1;
        need_d[i] = 1'b1;
      end
      if (eoi_hit[i]) need_d[i] = 1'b1;
      if (cfg_wr && widx == IW'(i)) need_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        cfg_q[i] <= CFG_RESET;
        dst_q[i] <= 8'h0;
      end
      irr_q        <= '0;
      need_q       <= '0;
      line_q       <= '0;
      sel_q        <= 8'h0;
      id_q         <= 4'h0;
      held_q       <= '0;
      msg_valid    <= 1'b0;
      msg_vector   <= 8'h0;
      msg_dmode    <= 3'h0;
      msg_level    <= 1'b0;
      msg_dest     <= 8'h0;
      msg_destmode <= 1'b0;
    end else begin
      line_q <= irq_in;
      irr_q  <= irr_d;
      need_q <= need_d;
      if (sel_wr) sel_q <= bus_wdata[7:0];
      if (win_wr && sel_q == 8'd0) id_q <= bus_wdata[27:24];
      if (dst_wr) dst_q[widx] <= bus_wdata[31:24];
      for (int i = 0; i < NUM_LINES; i++) begin
        if (cfg_wr && widx == IW'(i))
          cfg_q[i] <= (bus_wdata[16:0] & CFG_WMASK) | (cfg_q[i] & ~CFG_WMASK);
        if (eoi_hit[i]) cfg_q[i][14] <= 1'b0;
      end
      if (accept && msg_level) cfg_q[held_q][14] <= 1'b1;
      if (p_drop && p_lvl)     cfg_q[pick][14]   <= 1'b1;
      if (p_send) begin
        msg_valid    <= 1'b1;
        held_q       <= pick;
        msg_vector   <= pcfg[7:0];
        msg_dmode    <= pcfg[10:8];
        msg_level    <= pcfg[15];
        msg_dest     <= dst_q[pick];
        msg_destmode <= pcfg[11];
      end else if (accept) begin
        msg_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_redir_router_chk.sv
module irq_redir_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_en,
  input logic       bus_we,
  input logic       bus_byte,
  input logic [7:0] sel_q,
  input logic [3:0] id_q,
  input logic       msg_valid,
  input logic       msg_ready,
  input logic [7:0] msg_vector,
  input logic [2:0] msg_dmode,
  input logic       msg_level,
  input logic [7:0] msg_dest,
  input logic       msg_destmode
);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dmode)
      && $stable(msg_level) && $stable(msg_dest) && $stable(msg_destmode));

  p_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  p_fwd_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_dmode[2:1] == 2'b00);

  p_byte_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_we && bus_byte |=> $stable(sel_q) && $stable(id_q));
endmodule

bind irq_redir_router irq_redir_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_byte(bus_byte),
  .sel_q(sel_q), .id_q(id_q), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_dmode(msg_dmode), .msg_level(msg_level),
  .msg_dest(msg_dest), .msg_destmode(msg_destmode)
);

// File: tb/test_irq_redir_router.sv
`timescale 1ns/1ps
module test_irq_redir_router;
  localparam int N = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 0, bus_we = 0, bus_byte = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [N-1:0] irq_in = '0;
  logic eoi_valid = 0;
  logic [7:0] eoi_vector = 0;
  logic msg_valid, msg_ready = 0, msg_level, msg_destmode;
  logic [7:0] msg_vector, msg_dest;
  logic [2:0] msg_dmode;

  irq_redir_router #(.NUM_LINES(N)) i_irq_redir_router (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mdl [N];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_after(input logic [31:0] old, input logic [31:0] w);
    return (w & 32'h0001AFFF) | (old & 32'h00005000);
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit b = 0);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_byte = b; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_byte = 0;
  endtask

  task automatic rd(input logic [4:0] a, input bit b, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_byte = b; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0; bus_byte = 0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [31:0] d);
    wr(5'h00, {24'h0, idx});
    wr(5'h10, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [31:0] d);
    wr(5'h00, {24'h0, idx});
    rd(5'h10, 0, d);
  endtask

  task automatic reg_chk(input logic [7:0] idx, input logic [31:0] exp, input string req);
    logic [31:0] d;
    reg_rd(idx, d);
    chk(d === exp, req, d, exp);
  endtask

  task automatic wait_msg(output bit got);
    got = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (msg_valid) begin got = 1; break; end
    end
  endtask

  task automatic accept();
    @(negedge clk); msg_ready = 1;
    @(negedge clk); msg_ready = 0;
  endtask

  task automatic expect_quiet(input string req);
    bit seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (msg_valid) seen = 1;
    end
    chk(!seen, req, {31'h0, seen}, 32'h0);
  endtask

  task automatic expect_msg(input string req, input logic [7:0] v, input logic [2:0] m,
                            input bit l, input logic [7:0] d, input bit dm);
    bit got;
    wait_msg(got);
    chk(got, req, {31'h0, got}, 32'h1);
    if (got)
      chk({msg_vector, msg_dmode, msg_level, msg_dest, msg_destmode} === {v, m, l, d, dm}, req,
          {11'h0, msg_vector, msg_dmode, msg_level, msg_dest, msg_destmode},
          {11'h0, v, m, l, d, dm});
  endtask

  task automatic pulse(input int i);
    @(negedge clk); irq_in[i] = 1;
    repeat (2) @(negedge clk);
    irq_in[i] = 0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1; eoi_vector = v;
    @(negedge clk); eoi_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit same;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) mdl[i] = 32'h00010000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(msg_valid === 1'b0, "R1 msg_valid", {31'h0, msg_valid}, 0);
    reg_chk(8'h10, 32'h00010000, "R1 cfg0");
    reg_chk(8'h10 + 2 * 23, 32'h00010000, "R1 cfg23");
    reg_chk(8'h11, 32'h0, "R1 dest0");
    reg_chk(8'h00, 32'h0, "R1 id");

    // R2 select readback
    wr(5'h00, 32'hFFFF_FF3A);
    rd(5'h00, 0, d);
    chk(d === 32'h3A, "R2 select", d, 32'h3A);

    // R4 id, version, arbitration, unmapped
    reg_wr(8'h00, 32'hFFFFFFFF);
    reg_chk(8'h00, 32'h0F000000, "R4 id");
    reg_chk(8'h02, 32'h0F000000, "R4 arb mirror");
    reg_chk(8'h01, 32'h00170011, "R4 version");
    reg_wr(8'h01, 32'h12345678);
    reg_wr(8'h02, 32'h00000000);
    reg_chk(8'h01, 32'h00170011, "R4 version write ignored");
    reg_chk(8'h00, 32'h0F000000, "R4 arb write ignored");
    reg_wr(8'h05, 32'hFFFFFFFF);
    reg_chk(8'h05, 32'h0, "R4 unmapped");
    reg_chk(8'h40, 32'h0, "R4 beyond table");

    // R3 byte access
    wr(5'h00, 32'h1);
    for (int k = 0; k < 4; k++) begin
      rd(5'(16 + k), 1, d);
      chk(d === ((32'h00170011 >> (8 * k)) & 32'hFF), "R3 byte read", d, (32'h00170011 >> (8 * k)) & 32'hFF);
    end
    wr(5'h00, 32'h0);
    wr(5'h10, 32'h00000000, 1);
    reg_chk(8'h00, 32'h0F000000, "R3 byte write to id");
    wr(5'h00, 32'h22, 1);
    rd(5'h00, 0, d);
    chk(d === 32'h0, "R3 byte write to select", d, 32'h0);

    // R5 layout and read-only bits
    reg_wr(8'h10 + 10, 32'hFFFFFFFF);
    reg_chk(8'h10 + 10, 32'h0001AFFF, "R5 cfg writable");
    reg_wr(8'h11 + 10, 32'hFFFFFFFF);
    reg_chk(8'h11 + 10, 32'hFF000000, "R5 dest");
    reg_wr(8'h10 + 10, 32'h00010000);
    for (int k = 0; k < 30; k++) begin
      int e = 13 + int'($urandom % 11);
      logic [31:0] w = $urandom;
      reg_wr(8'(16 + 2 * e), w);
      mdl[e] = cfg_after(mdl[e], w);
      reg_chk(8'(16 + 2 * e), mdl[e], "R5 random cfg");
    end
    for (int e = 13; e < N; e++) reg_wr(8'(16 + 2 * e), 32'h00010000);
    expect_quiet("R5 no spurious message");

    // R6 R11 R12 edge delivery and hold
    reg_wr(8'h10 + 6, 32'h00000841);
    reg_wr(8'h11 + 6, 32'h5A000000);
    pulse(3);
    expect_msg("R6 R11 edge message", 8'h41, 3'd0, 0, 8'h5A, 1);
    same = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (!msg_valid || msg_vector !== 8'h41) same = 0;
    end
    chk(same, "R12 held until ready", {31'h0, same}, 1);
    accept();
    expect_quiet("R6 single message");

    // R6 masked edge discarded
    reg_wr(8'h10 + 8, 32'h00010042);
    pulse(4);
    reg_wr(8'h10 + 8, 32'h00000042);
    expect_quiet("R6 masked edge discarded");

    // R7 R8 level
    reg_wr(8'h11 + 12, 32'h11000000);
    reg_wr(8'h10 + 12, 32'h00018050);
    @(negedge clk); irq_in[6] = 1;
    expect_quiet("R7 masked level held");
    reg_wr(8'h10 + 12, 32'h00008150);
    expect_msg("R7 R11 level message", 8'h50, 3'd1, 1, 8'h11, 0);
    reg_chk(8'h10 + 12, 32'h00008150, "R8 rack clear before accept");
    accept();
    reg_chk(8'h10 + 12, 32'h0000C150, "R8 rack set on accept");
    reg_wr(8'h10 + 12, 32'h00008150);
    expect_quiet("R8 blocked while rack set");
    reg_chk(8'h10 + 12, 32'h0000C150, "R8 rack kept by write");

    // R9 eoi
    eoi(8'h51);
    reg_chk(8'h10 + 12, 32'h0000C150, "R9 mismatched eoi");
    eoi(8'h50);
    expect_msg("R9 redelivery after eoi", 8'h50, 3'd1, 1, 8'h11, 0);
    accept();

    // R9 R7 eoi and falling line in one cycle
    @(negedge clk); eoi_valid = 1; eoi_vector = 8'h50; irq_in[6] = 0;
    @(negedge clk); eoi_valid = 0;
    expect_quiet("R9 eoi with falling line");
    reg_chk(8'h10 + 12, 32'h00008150, "R9 rack cleared");
    @(negedge clk); irq_in[6] = 1;
    expect_msg("R7 level after collision", 8'h50, 3'd1, 1, 8'h11, 0);
    accept();
    @(negedge clk); irq_in[6] = 0;
    eoi(8'h50);
    expect_quiet("R9 eoi with line low");

    // R7 withdrawn request
    reg_wr(8'h10 + 14, 32'h00018060);
    @(negedge clk); irq_in[7] = 1;
    repeat (3) @(negedge clk);
    irq_in[7] = 0;
    reg_wr(8'h10 + 14, 32'h00008060);
    expect_quiet("R7 fall withdraws");

    // R10 mode filter
    reg_wr(8'h10 + 16, 32'h00000460);
    pulse(8);
    expect_quiet("R10 edge mode 4 silent");
    reg_chk(8'h10 + 16, 32'h00000460, "R10 edge cfg");
    reg_wr(8'h10 + 18, 32'h00008561);
    @(negedge clk); irq_in[9] = 1;
    expect_quiet("R10 level mode 5 silent");
    reg_chk(8'h10 + 18, 32'h0000C561, "R10 level rack set");
    @(negedge clk); irq_in[9] = 0;

    // R12 priority
    reg_wr(8'h10 + 20, 32'h00000070);
    reg_wr(8'h10 + 24, 32'h00000072);
    @(negedge clk); irq_in[10] = 1; irq_in[12] = 1;
    @(negedge clk); irq_in[10] = 0; irq_in[12] = 0;
    expect_msg("R12 lowest index first", 8'h70, 3'd0, 0, 8'h00, 0);
    accept();
    expect_msg("R12 second entry", 8'h72, 3'd0, 0, 8'h00, 0);
    accept();

    // R6 R11 random edge traffic
    for (int k = 0; k < 20; k++) begin
      int e = 13 + int'($urandom % 11);
      logic [7:0] v = 8'($urandom);
      logic [2:0] m = 3'($urandom % 2);
      bit dm = 1'($urandom);
      logic [7:0] ds = 8'($urandom);
      reg_wr(8'(17 + 2 * e), {ds, 24'h0});
      reg_wr(8'(16 + 2 * e), {20'h0, dm, m, v});
      pulse(e);
      expect_msg("R6 R11 random edge", v, m, 0, ds, dm);
      accept();
    end
    expect_quiet("R6 random tail");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule